// File: doc/BRIEF.md
# Raster-Op Logic and Alignment Unit

This unit is the word datapath of a bit-block-transfer sequencer. Each operation it accepts takes the current source word (Rs), destination word (Rd) and the two alignment holding words (Rt, Ru), and computes the next Rs and Rt. Three jobs share the unit. The first combines source and destination under any of the sixteen two-operand boolean raster functions. The second merges Rs into Rd under a mask for partial words at a scan-line edge. The third shifts and shift-ORs holding registers to realign source data that straddles a word boundary.

Two shift amounts are held inside the unit. A dedicated operation loads them once per transfer, and later shift operations either use one of them or take an amount from the immediate. For every raster function code presented, the unit also tells the sequencer whether that function reads the source word and whether it reads the destination word. The sequencer can then skip memory reads that are not needed. Results appear on registered outputs one cycle after an operation is accepted.

Top module: `rasterop_align_unit`

## Requirements
- R1: While reset is asserted, and until the first operation after reset, out_valid is 0 and rs_out and rt_out are 0. Both stored shift amounts reset to 0, so a shift by a stored amount returns its input unchanged.
- R2: Opcode bits [7:6]=00 selects a raster function whose code is opcode[3:0]. The result goes to Rs, and Rt passes through. The codes are: 0 all zeros, 1 NOT(S OR D), 2 D AND NOT S, 3 NOT S, 4 S AND NOT D, 5 NOT D, 6 S XOR D, 7 NOT(S AND D), 8 S AND D, 9 NOT(S XOR D), 10 D, 11 D OR NOT S, 12 S, 13 S OR NOT D, 14 S OR D, 15 all ones.
- R3: Raster code 12 returns Rs unchanged.
- R4: When opcode[7:6]=00, need_src is 0 only for codes 0, 5, 10 and 15, and need_dst is 0 only for codes 0, 3, 12 and 15. Both flags are 0 for any other opcode class.
- R5: Opcode bits [7:6]=10 is a field merge with imm as the mask. Rs becomes Rs where a mask bit is 1 and Rd where it is 0, and Rt passes through.
- R6: Opcode bits [7:6]=01 is a logical shift. opcode[1] is the direction (1 = right), and vacated bits fill with zero. opcode[5:4] selects the pair: 00 Rs from Rt, 01 Rt from Ru, 10 Rs from Rd, 11 Rt from Rt. opcode[3:2] selects the amount: 00 stored amount A, 01 stored amount B, 10 or 11 the immediate imm[5:0]. The register that is not the target passes through.
- R7: A shift with opcode[0]=1 ORs the shifted value into the target's current value instead of replacing it.
- R8: Opcode bits [7:6]=11 loads stored amount A from imm[5:0] and stored amount B from imm[11:6]. The new amounts are used from the next operation on and hold until the next load. That operation passes Rs and Rt through unchanged.
- R9: A shift amount of 32 or more gives a shifted value of zero. A replacing shift then yields zero, and an OR shift leaves the target unchanged.
- R10: out_valid is 1 exactly in the cycle after an operation is accepted (op_valid=1). rs_out and rt_out hold their values while no operation is accepted.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| op_valid | input | 1 | An operation is presented this cycle |
| opcode | input | 8 | Operation class and fields |
| imm | input | 32 | Immediate: field mask, shift amount or amount pair |
| rs_in | input | 32 | Current source/result word |
| rd_in | input | 32 | Current destination word |
| rt_in | input | 32 | Current alignment holding word |
| ru_in | input | 32 | Second alignment holding word |
| need_src | output | 1 | Selected raster code reads the source |
| need_dst | output | 1 | Selected raster code reads the destination |
| out_valid | output | 1 | Registered result valid |
| rs_out | output | 32 | Next Rs |
| rt_out | output | 32 | Next Rt |

## Verification
The hardest case to reach from the ports is a shift that uses a stored amount. Its result depends on a load issued earlier, and that earlier amount is invisible at the outputs. The stimulus interleaves random amount loads with random shifts, and the bench keeps its own copy of both amounts so that every later shift checks against the most recent load. Directed cases add amounts exactly at, just below and far above the word width, in both replace and OR forms.

// File: rtl/rasterop_pkg.sv
`timescale 1ns/1ps
package rasterop_pkg;

  localparam int OPC_W = 8;

  typedef enum logic [1:0] {
    CL_ROP   = 2'b00,
    CL_SHIFT = 2'b01,
    CL_FIELD = 2'b10,
    CL_SETSH = 2'b11
  } op_class_e;

  typedef enum logic [1:0] {
    PR_S_FROM_T = 2'b00,
    PR_T_FROM_U = 2'b01,
    PR_S_FROM_D = 2'b10,
    PR_T_FROM_T = 2'b11
  } shift_pair_e;

  typedef enum logic [1:0] {
    AM_STORED_A = 2'b00,
    AM_STORED_B = 2'b01,
    AM_IMM      = 2'b10,
    AM_IMM_ALT  = 2'b11
  } amt_src_e;

  // Raster code occupies {amt, right, accum} = opcode[3:0].
  typedef struct packed {
    op_class_e   cls;
    shift_pair_e pair;
    amt_src_e    amt;
    logic        right;
    logic        accum;
  } opcode_t;

endpackage

// File: rtl/rop_logic.sv
`timescale 1ns/1ps
module rop_logic #(
  parameter int DATA_W = 32
) (
  input  logic [3:0]        code,
  input  logic [DATA_W-1:0] src,
  input  logic [DATA_W-1:0] dst,
  output logic [DATA_W-1:0] result,
  output logic              uses_src,
  output logic              uses_dst
);

  // Each output bit selects one truth-table entry with index {S,D}.
  for (genvar i = 0; i < DATA_W; i++) begin : g_lane
    assign result[i] = code[{src[i], dst[i]}];
  end

  // S matters when the S=1 half differs from the S=0 half.
  assign uses_src = (code[3:2] != code[1:0]);
  // D matters when the D=1 entries differ from the D=0 entries.
  assign uses_dst = ({code[3], code[1]} != {code[2], code[0]});

endmodule

// File: rtl/logical_shifter.sv
`timescale 1ns/1ps
module logical_shifter #(
  parameter int DATA_W = 32,
  parameter int AMT_W  = $clog2(DATA_W) + 1
) (
  input  logic [DATA_W-1:0] value,
  input  logic [AMT_W-1:0]  amount,
  input  logic              right,
  output logic [DATA_W-1:0] shifted
);

  logic [DATA_W-1:0] stage [0:AMT_W];

  assign stage[0] = value;

  for (genvar k = 0; k < AMT_W; k++) begin : g_stage
    localparam int STEP = 1 << k;
    if (STEP < DATA_W) begin : g_move
      assign stage[k+1] = amount[k]
                          ? (right ? (stage[k] >> STEP) : (stage[k] << STEP))
                          : stage[k];
    end else begin : g_clear
      assign stage[k+1] = amount[k] ? '0 : stage[k];
    end
  end

  assign shifted = stage[AMT_W];

endmodule

// File: rtl/shift_amt_regs.sv
`timescale 1ns/1ps
module shift_amt_regs #(
  parameter int AMT_W = 6
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [AMT_W-1:0] amt_a_in,
  input  logic [AMT_W-1:0] amt_b_in,
  output logic [AMT_W-1:0] amt_a,
  output logic [AMT_W-1:0] amt_b
);

  logic [AMT_W-1:0] amt_a_d;
  logic [AMT_W-1:0] amt_b_d;

  always_comb begin
    amt_a_d = amt_a;
    amt_b_d = amt_b;
    if (load) begin
      amt_a_d = amt_a_in;
      amt_b_d = amt_b_in;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      amt_a <= '0;
      amt_b <= '0;
    end else begin
      amt_a <= amt_a_d;
      amt_b <= amt_b_d;
    end
  end

  AST_AMT_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    !load |=> ($stable(amt_a) && $stable(amt_b))) else $error("amounts changed without load"); // R8

  AST_AMT_LOADED: assert property (@(posedge clk) disable iff (!rst_n)
    load |=> (amt_a == $past(amt_a_in) && amt_b == $past(amt_b_in))) else $error("amount load lost"); // R8

endmodule

// File: rtl/rasterop_align_unit.sv
`timescale 1ns/1ps
module rasterop_align_unit
  import rasterop_pkg::*;
#(
  parameter int DATA_W      = 32,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              op_valid,
  input  logic [7:0]        opcode,
  input  logic [DATA_W-1:0] imm,
  input  logic [DATA_W-1:0] rs_in,
  input  logic [DATA_W-1:0] rd_in,
  input  logic [DATA_W-1:0] rt_in,
  input  logic [DATA_W-1:0] ru_in,
  output logic              need_src,
  output logic              need_dst,
  output logic              out_valid,
  output logic [DATA_W-1:0] rs_out,
  output logic [DATA_W-1:0] rt_out
);

  localparam int AMT_W = $clog2(DATA_W) + 1;

  // ---------------- reset release synchronizer ----------------
  logic [SYNC_STAGES-1:0] rst_pipe;
  logic                   rst_sync_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe <= '0;
    else        rst_pipe <= {rst_pipe[SYNC_STAGES-2:0], 1'b1};
  end
  assign rst_sync_n = rst_pipe[SYNC_STAGES-1];

  // ---------------- decode ----------------
  opcode_t op;
  assign op = opcode_t'(opcode);

  logic              is_rop;
  logic              target_is_s;
  assign is_rop      = (op.cls == CL_ROP);
  assign target_is_s = (op.pair == PR_S_FROM_T) || (op.pair == PR_S_FROM_D);

  // ---------------- raster function ----------------
  logic [DATA_W-1:0] rop_y;
  logic              rop_uses_s;
  logic              rop_uses_d;

  rop_logic #(.DATA_W(DATA_W)) u_rop (
    .code     (opcode[3:0]),
    .src      (rs_in),
    .dst      (rd_in),
    .result   (rop_y),
    .uses_src (rop_uses_s),
    .uses_dst (rop_uses_d)
  );

  assign need_src = is_rop && rop_uses_s;
  assign need_dst = is_rop && rop_uses_d;

  // ---------------- stored shift amounts ----------------
  logic             amt_load;
  logic [AMT_W-1:0] amt_a;
  logic [AMT_W-1:0] amt_b;

  assign amt_load = op_valid && (op.cls == CL_SETSH);

  shift_amt_regs #(.AMT_W(AMT_W)) u_amts (
    .clk      (clk),
    .rst_n    (rst_sync_n),
    .load     (amt_load),
    .amt_a_in (imm[AMT_W-1:0]),
    .amt_b_in (imm[2*AMT_W-1:AMT_W]),
    .amt_a    (amt_a),
    .amt_b    (amt_b)
  );

  // ---------------- shift operand select ----------------
  logic [AMT_W-1:0]  sh_amt;
  logic [DATA_W-1:0] sh_src;
  logic [DATA_W-1:0] sh_y;

  always_comb begin
    case (op.amt)
      AM_STORED_A: sh_amt = amt_a;
      AM_STORED_B: sh_amt = amt_b;
      default:     sh_amt = imm[AMT_W-1:0];
    endcase
    case (op.pair)
      PR_S_FROM_T: sh_src = rt_in;
      PR_T_FROM_U: sh_src = ru_in;
      PR_S_FROM_D: sh_src = rd_in;
      default:     sh_src = rt_in;
    endcase
  end

  logical_shifter #(.DATA_W(DATA_W), .AMT_W(AMT_W)) u_shift (
    .value   (sh_src),
    .amount  (sh_amt),
    .right   (op.right),
    .shifted (sh_y)
  );

  // ---------------- next-state ----------------
  logic [DATA_W-1:0] rs_nxt;
  logic [DATA_W-1:0] rt_nxt;

  always_comb begin
    rs_nxt = rs_in;
    rt_nxt = rt_in;
    case (op.cls)
      CL_ROP:   rs_nxt = rop_y;
      CL_SHIFT: begin
        if (target_is_s) rs_nxt = (op.accum ? rs_in : '0) | sh_y;
        else             rt_nxt = (op.accum ? rt_in : '0) | sh_y;
      end
      CL_FIELD: rs_nxt = ((rs_in ^ rd_in) & imm) ^ rd_in;
      default:  begin
        rs_nxt = rs_in;
        rt_nxt = rt_in;
      end
    endcase
  end

  logic [DATA_W-1:0] rs_d;
  logic [DATA_W-1:0] rt_d;
  assign rs_d = op_valid ? rs_nxt : rs_out;
  assign rt_d = op_valid ? rt_nxt : rt_out;

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      out_valid <= 1'b0;
      rs_out    <= '0;
      rt_out    <= '0;
    end else begin
      out_valid <= op_valid;
      rs_out    <= rs_d;
      rt_out    <= rt_d;
    end
  end

  // ---------------- assertions ----------------
  AST_VALID_AFTER_OP: assert property (@(posedge clk) disable iff (!rst_sync_n)
    op_valid |=> out_valid) else $error("missing out_valid"); // R10

  AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_sync_n)
    !op_valid |=> (!out_valid && $stable(rs_out) && $stable(rt_out))) else $error("output moved while idle"); // R10

  AST_COPY_S: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (op_valid && is_rop && opcode[3:0] == 4'd12) |=> (rs_out == $past(rs_in))) else $error("copy-S altered Rs"); // R3

  AST_ROP_KEEPS_T: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (op_valid && is_rop) |=> (rt_out == $past(rt_in))) else $error("raster op touched Rt"); // R2

  AST_NO_FETCH_CONST: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (is_rop && (opcode[3:0] == 4'd0 || opcode[3:0] == 4'd15)) |-> (!need_src && !need_dst)) else $error("constant code requests a read"); // R4

  AST_FIELD_MASK0: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (op_valid && op.cls == CL_FIELD) |=> ((rs_out & ~$past(imm)) == ($past(rd_in) & ~$past(imm)))) else $error("field merge lost Rd bits"); // R5

  AST_WIDE_SHIFT_ZERO: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (op_valid && op.cls == CL_SHIFT && !op.accum && target_is_s && sh_amt >= AMT_W'(DATA_W)) |=> (rs_out == '0)) else $error("wide shift left residue"); // R9

  AST_SETSH_PASS: assert property (@(posedge clk) disable iff (!rst_sync_n)
    amt_load |=> (rs_out == $past(rs_in) && rt_out == $past(rt_in))) else $error("amount load altered data"); // R8

endmodule

// File: tb/rasterop_align_unit_test.sv
`timescale 1ns/1ps
module rasterop_align_unit_test;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        op_valid = 1'b0;
  logic [7:0]  opcode = 8'h00;
  logic [31:0] imm = '0, rs_in = '0, rd_in = '0, rt_in = '0, ru_in = '0;
  logic        need_src, need_dst, out_valid;
  logic [31:0] rs_out, rt_out;

  int checks = 0;
  int failures = 0;
  bit finished = 0;
  int m_sha = 0;
  int m_shb = 0;

  always #2.5 clk = ~clk;

  rasterop_align_unit uut (
    .clk(clk), .rst_n(rst_n), .op_valid(op_valid), .opcode(opcode), .imm(imm),
    .rs_in(rs_in), .rd_in(rd_in), .rt_in(rt_in), .ru_in(ru_in),
    .need_src(need_src), .need_dst(need_dst), .out_valid(out_valid),
    .rs_out(rs_out), .rt_out(rt_out)
  );

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] exp_rop(int c, logic [31:0] s, logic [31:0] d);
    case (c)
      0:  return 32'h0;
      1:  return ~(s | d);
      2:  return d & ~s;
      3:  return ~s;
      4:  return s & ~d;
      5:  return ~d;
      6:  return s ^ d;
      7:  return ~(s & d);
      8:  return s & d;
      9:  return ~(s ^ d);
      10: return d;
      11: return d | ~s;
      12: return s;
      13: return s | ~d;
      14: return s | d;
      default: return 32'hFFFF_FFFF;
    endcase
  endfunction

  function automatic logic [31:0] sh(logic [31:0] v, int amt, bit right);
    if (amt >= 32) return 32'h0;
    return right ? (v >> amt) : (v << amt);
  endfunction

  // Returns {rs, rt} expected; updates the model amounts for loads.
  function automatic logic [63:0] model(logic [7:0] opc, logic [31:0] im,
      logic [31:0] s, logic [31:0] d, logic [31:0] t, logic [31:0] u);
    logic [31:0] rs_e = s, rt_e = t, src, val;
    int amt;
    case (opc[7:6])
      2'b00: rs_e = exp_rop(int'(opc[3:0]), s, d);
      2'b10: rs_e = (s & im) | (d & ~im);
      2'b11: begin m_sha = int'(im[5:0]); m_shb = int'(im[11:6]); end
      default: begin
        amt = (opc[3:2] == 2'b00) ? m_sha : (opc[3:2] == 2'b01) ? m_shb : int'(im[5:0]);
        case (opc[5:4])
          2'b00: src = t;
          2'b01: src = u;
          2'b10: src = d;
          default: src = t;
        endcase
        val = sh(src, amt, opc[1]);
        if (opc[5:4] == 2'b00 || opc[5:4] == 2'b10) rs_e = (opc[0] ? s : 32'h0) | val;
        else                                       rt_e = (opc[0] ? t : 32'h0) | val;
      end
    endcase
    return {rs_e, rt_e};
  endfunction

  task automatic do_op(logic [7:0] opc, logic [31:0] im, logic [31:0] s,
      logic [31:0] d, logic [31:0] t, logic [31:0] u);
    @(negedge clk);
    opcode = opc; imm = im; rs_in = s; rd_in = d; rt_in = t; ru_in = u;
    op_valid = 1'b1;
    @(negedge clk);
    op_valid = 1'b0;
  endtask

  task automatic run_check(string req, logic [7:0] opc, logic [31:0] im,
      logic [31:0] s, logic [31:0] d, logic [31:0] t, logic [31:0] u);
    logic [63:0] e;
    e = model(opc, im, s, d, t, u);
    do_op(opc, im, s, d, t, u);
    check({req, " valid"}, {31'h0, out_valid}, 32'h1);
    check({req, " rs"}, rs_out, e[63:32]);
    check({req, " rt"}, rt_out, e[31:0]);
  endtask

  function automatic logic [7:0] sop(int pair, int amt, bit right, bit acc);
    return {2'b01, 2'(pair), 2'(amt), right, acc};
  endfunction

  initial begin
    #(5.0 * 150000);
    if (!finished) begin
      failures++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    logic [31:0] s0, d0, held_rs, held_rt;
    void'($urandom(32'd20240611));
    repeat (3) @(negedge clk);
    // R1: reset state
    check("R1 reset valid", {31'h0, out_valid}, 32'h0);
    check("R1 reset rs", rs_out, 32'h0);
    check("R1 reset rt", rt_out, 32'h0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    check("R1 post-reset valid", {31'h0, out_valid}, 32'h0);
    // R1: stored amounts start at zero
    run_check("R1 stored A zero", sop(0, 0, 0, 0), 32'h0, 32'h1111_2222, 32'h0, 32'hA5A5_0F0F, 32'h0);
    run_check("R1 stored B zero", sop(1, 1, 1, 0), 32'h0, 32'h0, 32'h0, 32'h0, 32'h8001_7FFE);

    // R2 / R4: every raster code
    s0 = 32'hF0F0_CC33; d0 = 32'hFF00_AA55;
    for (int c = 0; c < 16; c++) begin
      @(negedge clk);
      opcode = 8'(c);
      #1;
      check($sformatf("R4 need_src code %0d", c), {31'h0, need_src},
            (c == 0 || c == 5 || c == 10 || c == 15) ? 32'h0 : 32'h1);
      check($sformatf("R4 need_dst code %0d", c), {31'h0, need_dst},
            (c == 0 || c == 3 || c == 12 || c == 15) ? 32'h0 : 32'h1);
      run_check($sformatf("R2 code %0d", c), 8'(c), 32'h0, s0, d0, 32'h1357_9BDF, 32'h0);
    end
    // R4: flags off outside raster class
    @(negedge clk); opcode = 8'h86; #1;
    check("R4 need_src field class", {31'h0, need_src}, 32'h0);
    check("R4 need_dst field class", {31'h0, need_dst}, 32'h0);
    // R3: copy S
    run_check("R3 copy S", 8'd12, 32'hFFFF_FFFF, 32'hDEAD_BEEF, 32'h0123_4567, 32'h0, 32'h0);

    // R5: field merge corner masks
    run_check("R5 mask zero", 8'h80, 32'h0, 32'hAAAA_AAAA, 32'h5555_5555, 32'h77, 32'h0);
    run_check("R5 mask ones", 8'h80, 32'hFFFF_FFFF, 32'hAAAA_AAAA, 32'h5555_5555, 32'h77, 32'h0);
    run_check("R5 mask edge", 8'h80, 32'h00FF_FF00, 32'h1234_5678, 32'h9ABC_DEF0, 32'h77, 32'h0);

    // R8: load amounts A=4, B=28
    run_check("R8 load pass", 8'hC0, (32'd28 << 6) | 32'd4, 32'hCAFE_F00D, 32'h0, 32'hBEEF_0001, 32'h0);
    run_check("R8 left by A", sop(0, 0, 0, 0), 32'h3F, 32'h0, 32'h0, 32'h8765_4321, 32'h0);
    run_check("R8 right by B", sop(1, 1, 1, 0), 32'h0, 32'h0, 32'h0, 32'h0, 32'hF000_0000);
    // R6: each pair, immediate amounts
    run_check("R6 S from D left", sop(2, 2, 0, 0), 32'd8, 32'hFFFF_FFFF, 32'h00AB_CDEF, 32'h0, 32'h0);
    run_check("R6 T from T right", sop(3, 3, 1, 0), 32'd31, 32'h0, 32'h0, 32'h8000_0000, 32'h0);
    run_check("R6 T from U left", sop(1, 2, 0, 0), 32'd1, 32'h0, 32'h0, 32'h1, 32'h8000_0001);
    // R7: OR accumulate (funnel join)
    run_check("R7 or right", sop(0, 1, 1, 1), 32'h0, 32'hFF00_0000, 32'h0, 32'hF000_000F, 32'h0);
    run_check("R7 or left T", sop(1, 0, 0, 1), 32'h0, 32'h0, 32'h0, 32'h0000_000F, 32'h1234_5678);
    // R9: wide amounts
    run_check("R9 imm 31", sop(0, 2, 0, 0), 32'd31, 32'h5, 32'h0, 32'hFFFF_FFFF, 32'h0);
    run_check("R9 imm 32", sop(0, 2, 0, 0), 32'd32, 32'h5, 32'h0, 32'hFFFF_FFFF, 32'h0);
    run_check("R9 imm 63 right", sop(2, 2, 1, 0), 32'd63, 32'h5, 32'hFFFF_FFFF, 32'h0, 32'h0);
    run_check("R9 or wide keeps", sop(3, 2, 1, 1), 32'd40, 32'h0, 32'h0, 32'h9999_1111, 32'h0);
    run_check("R8 amount B 40", 8'hC0, (32'd40 << 6) | 32'd0, 32'h0, 32'h0, 32'h0, 32'h0);
    run_check("R9 stored B wide", sop(0, 1, 0, 0), 32'h0, 32'h7, 32'h0, 32'hFFFF_FFFF, 32'h0);

    // R10: outputs hold while idle
    run_check("R10 setup", 8'd6, 32'h0, 32'h0F0F_0F0F, 32'h00FF_00FF, 32'h2468_ACE0, 32'h0);
    held_rs = rs_out; held_rt = rt_out;
    @(negedge clk);
    opcode = 8'd15; rs_in = 32'h1; rd_in = 32'h2; rt_in = 32'h3;
    repeat (3) @(negedge clk);
    check("R10 idle valid", {31'h0, out_valid}, 32'h0);
    check("R10 idle rs", rs_out, held_rs);
    check("R10 idle rt", rt_out, held_rt);

    // Random mix
    for (int n = 0; n < 400; n++) begin
      logic [7:0] opc;
      string tag;
      opc = 8'($urandom);
      case (opc[7:6])
        2'b00: tag = "R2 rand rop";
        2'b01: tag = opc[0] ? "R7 rand shift-or" : "R6 rand shift";
        2'b10: tag = "R5 rand field";
        default: tag = "R8 rand load";
      endcase
      run_check(tag, opc, $urandom, $urandom, $urandom, $urandom, $urandom);
    end

    finished = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule